// File: doc/BRIEF.md
# Stack-Based Integer Arithmetic Coprocessor

This block is a host-driven integer arithmetic engine built around a ten-entry operand stack. The host places operands by pushing an entry and then writing the 32-bit top entry one byte at a time. It requests work by writing an 8-bit command code, and it reads the outcome from an 8-bit status port and from the byte-wide view of the top entry.

Unary integer commands replace the top entry with their result. Binary commands take the entry below the top as the left operand and the top entry as the right operand. They remove both and push a single result. Addition, subtraction, both multiplies and the shifts finish in one cycle. Division and modulus run through a bit-serial restoring divider, and the status port reads busy while it works. The upper 32 bits of the latest product are kept, and a dedicated command can push them.

Top module: `sc_stack_calc`

## Requirements
- R1: After reset the stack is empty, the status port reads 1 (OK), the retained upper product word is 0, and reading any byte of the top entry returns 0.
- R2: Byte select 0 addresses bits 7:0 of the top entry, and select 3 addresses bits 31:24. A byte write changes only the selected byte of the top entry. A byte write to an empty stack has no effect.
- R3: Stack commands: 0x01 pushes zero, 0x02 pushes a copy of the top, 0x03 removes the top, 0x04 exchanges the top two entries, 0x05 pushes a copy of the second entry, and 0x10 overwrites the top with 1.
- R4: A push onto a full stack (10 entries) and any unassigned command code set the status to 3 (overflow) and leave the stack unchanged. The depth never exceeds 10.
- R5: A command that needs more entries than the stack holds sets the status to 4 (underflow) and leaves the stack unchanged.
- R6: Unary commands on the top entry: 0x20 two's-complement negate, 0x21 bitwise invert, 0x25 absolute value (0x80000000 maps to itself), 0x26 sign, which yields 0xFFFFFFFF, 0 or 1.
- R7: Shifts take the second entry as the value and bits 4:0 of the top entry as the amount: 0x22 left, 0x23 logical right, 0x24 arithmetic right.
- R8: 0x30 adds and 0x31 subtracts (second minus top). 0x32 multiplies unsigned and 0x33 multiplies signed. Each multiply pushes the low 32 bits of the product and retains the high 32 bits.
- R9: 0x38 pushes the retained upper product word. 0x00 empties the stack, clears the retained word and sets the status to OK.
- R10: 0x34, 0x35, 0x36 and 0x37 give unsigned quotient, signed quotient, unsigned remainder and signed remainder of second divided by top. Signed quotients truncate toward zero, and a signed remainder takes the sign of the dividend. The status reads 0 (busy) for at least 32 cycles before the result appears.
- R11: A divide or modulus by zero sets the status to 2 and leaves both operands on the stack.
- R12: Commands issued while the status reads busy are ignored.
- R13: Every completed command writes its outcome into the status. Command 0x06 sets the status to OK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_en | input | 1 | Command strobe, one cycle per command |
| cmd | input | 8 | Command code |
| wr_en | input | 1 | Byte write strobe for the top entry |
| wr_sel | input | 2 | Byte lane selected for writing |
| wr_data | input | 8 | Byte written into the top entry |
| rd_sel | input | 2 | Byte lane selected for reading |
| rd_data | output | 8 | Selected byte of the top entry (0 when empty) |
| status | output | 8 | 0 busy, 1 OK, 2 divide by zero, 3 overflow, 4 underflow |

## Verification
The assertions assume that the host never raises a command strobe and a byte write strobe in the same cycle. They also assume that each command is a single-cycle pulse, so that the depth and top entry seen one cycle later are the effect of that command alone. The stimulus drives every command and every byte write as an isolated one-cycle strobe. It waits for the status to leave busy before issuing the next command, except in the directed cases that deliberately probe R12. Operand values are drawn partly at random and partly from the edges: 0, 1, all ones, 0x80000000 and small values, so that sign handling and zero divisors come up often.

// File: rtl/sc_pkg.sv
`timescale 1ns/1ps
package sc_pkg;
    localparam logic [7:0] OP_INIT    = 8'h00;
    localparam logic [7:0] OP_PUSH0   = 8'h01;
    localparam logic [7:0] OP_DUP     = 8'h02;
    localparam logic [7:0] OP_DROP    = 8'h03;
    localparam logic [7:0] OP_SWAP    = 8'h04;
    localparam logic [7:0] OP_OVER    = 8'h05;
    localparam logic [7:0] OP_CLR_ST  = 8'h06;
    localparam logic [7:0] OP_ONE     = 8'h10;
    localparam logic [7:0] OP_NEG     = 8'h20;
    localparam logic [7:0] OP_NOT     = 8'h21;
    localparam logic [7:0] OP_SHL     = 8'h22;
    localparam logic [7:0] OP_SHR     = 8'h23;
    localparam logic [7:0] OP_SAR     = 8'h24;
    localparam logic [7:0] OP_ABS     = 8'h25;
    localparam logic [7:0] OP_SGN     = 8'h26;
    localparam logic [7:0] OP_ADD     = 8'h30;
    localparam logic [7:0] OP_SUB     = 8'h31;
    localparam logic [7:0] OP_MULU    = 8'h32;
    localparam logic [7:0] OP_MULS    = 8'h33;
    localparam logic [7:0] OP_DIVU    = 8'h34;
    localparam logic [7:0] OP_DIVS    = 8'h35;
    localparam logic [7:0] OP_MODU    = 8'h36;
    localparam logic [7:0] OP_MODS    = 8'h37;
    localparam logic [7:0] OP_HIWORD  = 8'h38;

    localparam logic [7:0] ST_BUSY = 8'd0;
    localparam logic [7:0] ST_OK   = 8'd1;
    localparam logic [7:0] ST_DIV0 = 8'd2;
    localparam logic [7:0] ST_OVF  = 8'd3;
    localparam logic [7:0] ST_UDF  = 8'd4;
endpackage

// File: rtl/sc_alu.sv
`timescale 1ns/1ps
module sc_alu
    import sc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [7:0]   op,
    input  logic [W-1:0] tos,
    input  logic [W-1:0] nos,
    output logic [W-1:0] res,
    output logic [W-1:0] hi
);
    localparam int SHW = $clog2(W);

    logic [2*W-1:0] prod_u;
    logic [2*W-1:0] prod_s;
    logic [SHW-1:0] amt;

    assign amt    = tos[SHW-1:0];
    assign prod_u = {{W{1'b0}}, nos} * {{W{1'b0}}, tos};
    assign prod_s = $signed({{W{nos[W-1]}}, nos}) * $signed({{W{tos[W-1]}}, tos});
    assign hi     = (op == OP_MULS) ? prod_s[2*W-1:W] : prod_u[2*W-1:W];

    always_comb begin
        case (op)
            OP_NEG:  res = -tos;
            OP_NOT:  res = ~tos;
            OP_ABS:  res = tos[W-1] ? -tos : tos;
            OP_SGN:  res = tos[W-1] ? {W{1'b1}} : ((tos == '0) ? '0 : W'(1));
            OP_SHL:  res = nos << amt;
            OP_SHR:  res = nos >> amt;
            OP_SAR:  res = $signed(nos) >>> amt;
            OP_ADD:  res = nos + tos;
            OP_SUB:  res = nos - tos;
            OP_MULU: res = prod_u[W-1:0];
            OP_MULS: res = prod_s[W-1:0];
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/sc_divider.sv
`timescale 1ns/1ps
module sc_divider #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         done,
    output logic [W-1:0] quot,
    output logic [W-1:0] rem
);
    localparam int CNTW = $clog2(W);

    typedef struct packed {
        logic            run;
        logic            done;
        logic [CNTW-1:0] cnt;
        logic [W-1:0]    rem;
        logic [W-1:0]    quo;
        logic [W-1:0]    dvs;
    } div_t;

    div_t q, d;
    logic [W:0] trial;

    assign trial = {q.rem, q.quo[W-1]} - {1'b0, q.dvs};

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (start) begin
            d.run = 1'b1;
            d.cnt = '0;
            d.rem = '0;
            d.quo = dividend;
            d.dvs = divisor;
        end else if (q.run) begin
            if (!trial[W]) begin
                d.rem = trial[W-1:0];
                d.quo = {q.quo[W-2:0], 1'b1};
            end else begin
                d.rem = {q.rem[W-2:0], q.quo[W-1]};
                d.quo = {q.quo[W-2:0], 1'b0};
            end
            d.cnt = q.cnt + 1'b1;
            if (q.cnt == CNTW'(W-1)) begin
                d.run  = 1'b0;
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done = q.done;
    assign quot = q.quo;
    assign rem  = q.rem;
endmodule

// File: rtl/sc_stack_calc.sv
`timescale 1ns/1ps
module sc_stack_calc
    import sc_pkg::*;
#(
    parameter int DEPTH = 10,
    parameter int W     = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_en,
    input  logic [7:0] cmd,
    input  logic       wr_en,
    input  logic [1:0] wr_sel,
    input  logic [7:0] wr_data,
    input  logic [1:0] rd_sel,
    output logic [7:0] rd_data,
    output logic [7:0] status
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] ent;
        logic [CW-1:0]           cnt;
        logic [7:0]              stat;
        logic [W-1:0]            hi;
        logic                    busy;
        logic                    is_mod;
        logic                    neg_q;
        logic                    neg_r;
    } calc_t;

    calc_t st_q, st_d;

    logic [CW-1:0] tos_idx, nos_idx;
    logic [W-1:0]  tos, nos, alu_res, alu_hi;
    logic [W-1:0]  dv_a, dv_b, dv_quot, dv_rem, q_fix, r_fix;
    logic          full, has1, has2, sgn_op, dv_start, dv_done;

    assign tos_idx = st_q.cnt - 1'b1;
    assign nos_idx = st_q.cnt - 2'd2;
    assign has1    = st_q.cnt != '0;
    assign has2    = st_q.cnt > CW'(1);
    assign full    = st_q.cnt == FULL;
    assign tos     = has1 ? st_q.ent[tos_idx] : '0;
    assign nos     = has2 ? st_q.ent[nos_idx] : '0;

    sc_alu #(.W(W)) u_alu (
        .op  (cmd),
        .tos (tos),
        .nos (nos),
        .res (alu_res),
        .hi  (alu_hi)
    );

    assign sgn_op = (cmd == OP_DIVS) || (cmd == OP_MODS);
    assign dv_a   = (sgn_op && nos[W-1]) ? -nos : nos;
    assign dv_b   = (sgn_op && tos[W-1]) ? -tos : tos;

    sc_divider #(.W(W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (dv_start),
        .dividend (dv_a),
        .divisor  (dv_b),
        .done     (dv_done),
        .quot     (dv_quot),
        .rem      (dv_rem)
    );

    assign q_fix = st_q.neg_q ? -dv_quot : dv_quot;
    assign r_fix = st_q.neg_r ? -dv_rem : dv_rem;

    always_comb begin
        st_d     = st_q;
        dv_start = 1'b0;
        if (st_q.busy) begin
            if (dv_done) begin
                st_d.ent[nos_idx] = st_q.is_mod ? r_fix : q_fix;
                st_d.cnt          = st_q.cnt - 1'b1;
                st_d.stat         = ST_OK;
                st_d.busy         = 1'b0;
            end
        end else if (cmd_en) begin
            st_d.stat = ST_OK;
            case (cmd)
                OP_INIT: begin
                    st_d.cnt = '0;
                    st_d.hi  = '0;
                end
                OP_PUSH0, OP_HIWORD: begin
                    if (full) st_d.stat = ST_OVF;
                    else begin
                        st_d.ent[st_q.cnt] = (cmd == OP_HIWORD) ? st_q.hi : '0;
                        st_d.cnt           = st_q.cnt + 1'b1;
                    end
                end
                OP_DUP: begin
                    if (!has1)     st_d.stat = ST_UDF;
                    else if (full) st_d.stat = ST_OVF;
                    else begin
                        st_d.ent[st_q.cnt] = tos;
                        st_d.cnt           = st_q.cnt + 1'b1;
                    end
                end
                OP_OVER: begin
                    if (!has2)     st_d.stat = ST_UDF;
                    else if (full) st_d.stat = ST_OVF;
                    else begin
                        st_d.ent[st_q.cnt] = nos;
                        st_d.cnt           = st_q.cnt + 1'b1;
                    end
                end
                OP_DROP: begin
                    if (!has1) st_d.stat = ST_UDF;
                    else       st_d.cnt  = st_q.cnt - 1'b1;
                end
                OP_SWAP: begin
                    if (!has2) st_d.stat = ST_UDF;
                    else begin
                        st_d.ent[tos_idx] = nos;
                        st_d.ent[nos_idx] = tos;
                    end
                end
                OP_CLR_ST: ;
                OP_ONE: begin
                    if (!has1) st_d.stat = ST_UDF;
                    else       st_d.ent[tos_idx] = W'(1);
                end
                OP_NEG, OP_NOT, OP_ABS, OP_SGN: begin
                    if (!has1) st_d.stat = ST_UDF;
                    else       st_d.ent[tos_idx] = alu_res;
                end
                OP_SHL, OP_SHR, OP_SAR, OP_ADD, OP_SUB, OP_MULU, OP_MULS: begin
                    if (!has2) st_d.stat = ST_UDF;
                    else begin
                        st_d.ent[nos_idx] = alu_res;
                        st_d.cnt          = st_q.cnt - 1'b1;
                        if (cmd == OP_MULU || cmd == OP_MULS) st_d.hi = alu_hi;
                    end
                end
                OP_DIVU, OP_DIVS, OP_MODU, OP_MODS: begin
                    if (!has2)            st_d.stat = ST_UDF;
                    else if (tos == '0)   st_d.stat = ST_DIV0;
                    else begin
                        dv_start     = 1'b1;
                        st_d.busy    = 1'b1;
                        st_d.is_mod  = (cmd == OP_MODU) || (cmd == OP_MODS);
                        st_d.neg_q   = sgn_op && (nos[W-1] ^ tos[W-1]);
                        st_d.neg_r   = sgn_op && nos[W-1];
                    end
                end
                default: st_d.stat = ST_OVF;
            endcase
        end else if (wr_en && has1) begin
            st_d.ent[tos_idx][{wr_sel, 3'b000} +: 8] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.stat <= ST_OK;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = tos[{rd_sel, 3'b000} +: 8];
    assign status  = st_q.busy ? ST_BUSY : st_q.stat;

    logic [CW-1:0] depth_w;
    logic          busy_w;
    assign depth_w = st_q.cnt;
    assign busy_w  = st_q.busy;
endmodule

// File: rtl/sc_stack_calc_chk.sv
`timescale 1ns/1ps
module sc_stack_calc_chk #(
    parameter int DEPTH = 10,
    parameter int W     = 32,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_en,
    input logic [7:0]    cmd,
    input logic          busy,
    input logic          div_done,
    input logic [CW-1:0] depth,
    input logic [W-1:0]  tos,
    input logic [7:0]    status
);
    logic is_div;
    assign is_div = (cmd >= 8'h34) && (cmd <= 8'h37);

    assert_depth_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        depth <= CW'(DEPTH));

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_en && !busy && cmd == 8'h01 && depth == CW'(DEPTH)
        |=> depth == CW'(DEPTH) && status == 8'd3);

    assert_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_en && !busy && cmd == 8'h03 && depth == '0
        |=> depth == '0 && status == 8'd4);

    assert_sign_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_en && !busy && cmd == 8'h26 && depth != '0
        |=> (tos == '0 || tos == W'(1) || tos == {W{1'b1}}));

    assert_init_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_en && !busy && cmd == 8'h00 |=> depth == '0 && status == 8'd1);

    assert_div_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_en && !busy && is_div && depth > CW'(1) && tos != '0
        |=> status == 8'd0);

    assert_div_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_en && !busy && is_div && depth > CW'(1) && tos == '0
        |=> status == 8'd2 && $stable(depth));

    assert_busy_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !div_done |=> $stable(depth));
endmodule

bind sc_stack_calc sc_stack_calc_chk #(.DEPTH(DEPTH), .W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_en   (cmd_en),
    .cmd      (cmd),
    .busy     (busy_w),
    .div_done (dv_done),
    .depth    (depth_w),
    .tos      (tos),
    .status   (status)
);

// File: tb/sc_stack_calc_test.sv
`timescale 1ns/1ps
module sc_stack_calc_test;
    localparam int DEPTH = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_en = 1'b0;
    logic [7:0] cmd = '0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_sel = '0;
    logic [7:0] rd_data;
    logic [7:0] status;

    int checks = 0;
    int fails  = 0;

    logic [31:0] stk[$];
    logic [7:0]  exp_st = 8'd1;
    logic [31:0] exp_hi = '0;

    always #4 clk = ~clk;

    sc_stack_calc #(.DEPTH(DEPTH), .W(32)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_en(cmd_en), .cmd(cmd),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .status(status)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_cmd(input logic [7:0] c);
        cmd_en = 1'b1; cmd = c;
        @(negedge clk);
        cmd_en = 1'b0;
    endtask

    task automatic wr_byte(input logic [1:0] s, input logic [7:0] v);
        wr_en = 1'b1; wr_sel = s; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_word(input logic [31:0] v);
        for (int i = 0; i < 4; i++) wr_byte(2'(i), v[8*i +: 8]);
    endtask

    task automatic rd_word(output logic [31:0] v);
        for (int i = 0; i < 4; i++) begin
            rd_sel = 2'(i);
            #0.5;
            v[8*i +: 8] = rd_data;
        end
        @(negedge clk);
    endtask

    function automatic logic [31:0] f_unary(input logic [7:0] op, input logic [31:0] b);
        case (op)
            8'h20: return -b;
            8'h21: return ~b;
            8'h25: return b[31] ? -b : b;
            default: return b[31] ? 32'hFFFF_FFFF : (b == 0 ? 32'd0 : 32'd1);
        endcase
    endfunction

    function automatic logic [63:0] f_prod(input logic [7:0] op, input logic [31:0] a, input logic [31:0] b);
        longint sa, sb;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        if (op == 8'h33) return 64'(sa * sb);
        return {32'd0, a} * {32'd0, b};
    endfunction

    function automatic logic [31:0] f_binary(input logic [7:0] op, input logic [31:0] a, input logic [31:0] b);
        longint sa, sb;
        logic [63:0] p;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        p  = f_prod(op, a, b);
        case (op)
            8'h22: return a << b[4:0];
            8'h23: return a >> b[4:0];
            8'h24: return 32'($signed(a) >>> b[4:0]);
            8'h30: return a + b;
            8'h31: return a - b;
            8'h32, 8'h33: return p[31:0];
            8'h34: return a / b;
            8'h35: return 32'(sa / sb);
            8'h36: return a % b;
            default: return 32'(sa % sb);
        endcase
    endfunction

    function automatic string req_of(input logic [7:0] op);
        case (op)
            8'h00, 8'h38: return "R9";
            8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h10: return "R3";
            8'h06: return "R13";
            8'h20, 8'h21, 8'h25, 8'h26: return "R6";
            8'h22, 8'h23, 8'h24: return "R7";
            8'h30, 8'h31, 8'h32, 8'h33: return "R8";
            8'h34, 8'h35, 8'h36, 8'h37: return "R10";
            default: return "R4";
        endcase
    endfunction

    // returns 1 when the model expects the divider to start
    function automatic bit model(input logic [7:0] op);
        int n = stk.size();
        logic [31:0] a, b, t;
        logic [63:0] p;
        bit starts = 0;
        a = (n >= 2) ? stk[n-2] : '0;
        b = (n >= 1) ? stk[n-1] : '0;
        exp_st = 8'd1;
        case (op)
            8'h00: begin stk.delete(); exp_hi = '0; end
            8'h01: if (n == DEPTH) exp_st = 8'd3; else stk.push_back('0);
            8'h38: if (n == DEPTH) exp_st = 8'd3; else stk.push_back(exp_hi);
            8'h02: if (n < 1) exp_st = 8'd4; else if (n == DEPTH) exp_st = 8'd3; else stk.push_back(b);
            8'h05: if (n < 2) exp_st = 8'd4; else if (n == DEPTH) exp_st = 8'd3; else stk.push_back(a);
            8'h03: if (n < 1) exp_st = 8'd4; else t = stk.pop_back();
            8'h04: if (n < 2) exp_st = 8'd4; else begin stk[n-1] = a; stk[n-2] = b; end
            8'h06: ;
            8'h10: if (n < 1) exp_st = 8'd4; else stk[n-1] = 32'd1;
            8'h20, 8'h21, 8'h25, 8'h26:
                if (n < 1) exp_st = 8'd4; else stk[n-1] = f_unary(op, b);
            8'h22, 8'h23, 8'h24, 8'h30, 8'h31, 8'h32, 8'h33:
                if (n < 2) exp_st = 8'd4;
                else begin
                    t = stk.pop_back();
                    stk[n-2] = f_binary(op, a, b);
                    if (op == 8'h32 || op == 8'h33) begin
                        p = f_prod(op, a, b);
                        exp_hi = p[63:32];
                    end
                end
            8'h34, 8'h35, 8'h36, 8'h37:
                if (n < 2) exp_st = 8'd4;
                else if (b == 0) exp_st = 8'd2;
                else begin
                    starts = 1;
                    t = stk.pop_back();
                    stk[n-2] = f_binary(op, a, b);
                end
            default: exp_st = 8'd3;
        endcase
        return starts;
    endfunction

    task automatic check_state(input string req);
        logic [31:0] w;
        check(req, 32'(status), 32'(exp_st));
        rd_word(w);
        check(req, w, (stk.size() == 0) ? 32'd0 : stk[stk.size()-1]);
    endtask

    task automatic wait_div(input string req);
        int cyc = 0;
        check({req, " busy"}, 32'(status), 32'd0);
        while (status == 8'd0 && cyc < 200) begin
            cyc++;
            @(negedge clk);
        end
        checks++;
        if (cyc < 32) begin
            fails++;
            $display("FAIL %s busy_cycles actual=%0d expected>=32", req, cyc);
        end
    endtask

    task automatic run(input logic [7:0] op);
        bit starts;
        starts = model(op);
        do_cmd(op);
        if (starts) wait_div(req_of(op));
        check_state(req_of(op));
    endtask

    task automatic push_val(input logic [31:0] v);
        run(8'h01);
        wr_word(v);
        stk[stk.size()-1] = v;
        check_state("R2");
    endtask

    function automatic logic [31:0] pick_val();
        case ($urandom % 7)
            0: return 32'd0;
            1: return 32'd1;
            2: return 32'hFFFF_FFFF;
            3: return 32'h8000_0000;
            4: return $urandom % 20;
            5: return -($urandom % 20);
            default: return $urandom;
        endcase
    endfunction

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] w;
        logic [7:0] ops [24];
        void'($urandom(32'd4711));
        ops = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h10, 8'h20,
                8'h21, 8'h22, 8'h23, 8'h24, 8'h25, 8'h26, 8'h30, 8'h31,
                8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h03};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 status", 32'(status), 32'd1);
        rd_word(w);
        check("R1 top", w, 32'd0);
        run(8'h38);                       // R1: retained word is zero
        run(8'h00);

        // R5: underflow on empty
        run(8'h03);
        run(8'h04);

        // R2: write to empty ignored, then byte lanes
        wr_byte(2'd1, 8'hAB);
        run(8'h01);
        wr_byte(2'd0, 8'h11);
        wr_byte(2'd1, 8'h22);
        wr_byte(2'd2, 8'h33);
        wr_byte(2'd3, 8'h44);
        stk[0] = 32'h4433_2211;
        check_state("R2 lanes");
        wr_byte(2'd2, 8'h00);
        stk[0] = 32'h4400_2211;
        check_state("R2 single");

        // R4: fill, overflow, bad code
        for (int i = 1; i < DEPTH; i++) push_val(32'(i * 3));
        run(8'h01);
        run(8'h02);
        run(8'h7F);
        run(8'h06);                       // R13
        run(8'h00);

        // R10 / R11: signed division corners
        push_val(32'h8000_0000); push_val(32'hFFFF_FFFF); run(8'h35);
        push_val(-32'sd7);        push_val(32'd2);         run(8'h37);
        push_val(32'd7);          push_val(-32'sd2);       run(8'h35);
        push_val(32'd5);          push_val(32'd0);         run(8'h34);
        run(8'h06);

        // R12: commands during busy are ignored
        push_val(32'd100); push_val(32'd7);
        void'(model(8'h36));
        do_cmd(8'h36);
        do_cmd(8'h03);
        do_cmd(8'h01);
        while (status == 8'd0) @(negedge clk);
        check_state("R12");

        // R8 / R9: product high word
        push_val(32'hFFFF_FFFF); push_val(32'hFFFF_FFFF); run(8'h32); run(8'h38);
        push_val(32'hFFFF_FFFF); push_val(32'd3);         run(8'h33); run(8'h38);
        run(8'h00);
        run(8'h38);

        // random mix
        for (int k = 0; k < 400; k++) begin
            int r = $urandom % 12;
            if (r < 4 && stk.size() < DEPTH) push_val(pick_val());
            else if (r == 4) run(8'hC0 | 8'($urandom % 16));
            else if (r == 5 && ($urandom % 8) == 0) run(8'h00);
            else run(ops[$urandom % 24]);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule